// File: doc/BRIEF.md
# Auxiliary DC-Link Switch Sequencer for a Dual Two-Level Inverter

This block drives the four auxiliary switches that tie a dual two-level inverter to a shared DC supply when the two inverters feed the opposite ends of an open-end motor winding. The switches form two pairs. Pair A (SW1 with SW3) connects inverter 1 and pair B (SW2 with SW4) connects inverter 2. The block takes the 3-bit switching state of each inverter and drives the four gate commands. It also raises a fault flag when the requested state pair is forbidden.

There are two operating modes.

- **Decode mode.** A pair is opened whenever its inverter sits in a zero state. This denies triplen-harmonic current a return path. Pairs that do not need opening stay closed.
- **Alternate mode.** The two pairs take turns at a fixed rate, so only one inverter is tied to the DC link at any moment. Every hand-over has a programmable gap in which both pairs are open.

The controller is a five-state machine:

- `S_DECODE`: outputs follow the registered decode result.
- `S_GAP_BA`: both pairs open; this is the entry gap from decode and the gap after pair B.
- `S_A_ON`: pair A closed.
- `S_GAP_AB`: both pairs open; this is the gap after pair A.
- `S_B_ON`: pair B closed.

Its transitions are:

- `DECODE->GAP_BA` when the mode input rises.
- `GAP_BA->A_ON` and `GAP_AB->B_ON` when the dead interval ends.
- `A_ON->GAP_AB` and `B_ON->GAP_BA` when the on-interval ends.
- Any alternate state goes `->DECODE` when the mode input falls.

Top module: `aux_switch_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, all four gate commands are 0 (open) and the fault flag is 0.
- R2: A state code holds the pole signs of phases a, b and c in bits 2, 1 and 0, where 1 means positive. Codes 000 and 111 are the zero states. In decode mode, when inverter 1's state sampled at an edge is a zero state, gates bit 0 (SW1) and bit 2 (SW3) are 0 from that edge on.
- R3: In decode mode, when inverter 2's state sampled at an edge is a zero state, gates bit 1 (SW2) and bit 3 (SW4) are 0 from that edge on.
- R4: In decode mode, when both sampled states are active (non-zero) and the pair is not forbidden, all four gates are 1 (closed) from that edge on.
- R5: A pair of states is forbidden when both are active and inverter 2's code is the bitwise complement of inverter 1's code. The fault flag equals the forbidden status of the states sampled at the previous edge, in both modes.
- R6: In decode mode, a forbidden pair opens all four gates from the edge that samples it.
- R7: Alternate mode cycles through four intervals: a gap of D+1 cycles, pair A closed (bits 0 and 2 = 1) for P+1 cycles, a gap of D+1 cycles, then pair B closed (bits 1 and 3 = 1) for P+1 cycles. D is the dead length and P is the half-period. The first gap starts at the edge that samples the mode input high.
- R8: In alternate mode the two pairs are never closed together, and a pair only closes if the other pair was open in the previous cycle.
- R9: Sampling the mode input low in any alternate state returns the block to decode behaviour from that edge.
- R10: In alternate mode the inverter states have no effect on the gate commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_mode_i | input | 1 | 1 = fixed-rate alternation, 0 = zero-state decode |
| inv1_state_i | input | 3 | Inverter 1 pole signs {a,b,c}, 1 = positive |
| inv2_state_i | input | 3 | Inverter 2 pole signs {a,b,c}, 1 = positive |
| half_period_i | input | 16 | On-interval length minus one, in cycles |
| dead_len_i | input | 8 | Gap length minus one, in cycles |
| aux_close_o | output | 4 | Gate commands {SW4,SW3,SW2,SW1}, 1 = closed |
| fault_o | output | 1 | Forbidden state pair sampled at the previous edge |

## Verification
The assertions assume that the half-period and dead-length inputs stay constant while the block is alternating. The on-phase and gap checks compare a running count against these inputs, and they do not cover a limit that moves under them. The stimulus changes these inputs only while the block is in decode mode. While alternating, the stimulus drives only the inverter states and the mode input, each updated between clock edges. The assertions also assume the inverter states are valid 3-bit codes on every cycle, and the bench always drives defined values.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

    localparam int unsigned STATE_W = 3;
    localparam int unsigned COMBO_N = 1 << (2 * STATE_W);

    typedef enum logic [2:0] {
        S_DECODE = 3'd0,
        S_GAP_BA = 3'd1,
        S_A_ON   = 3'd2,
        S_GAP_AB = 3'd3,
        S_B_ON   = 3'd4
    } seq_state_e;

    // An all-equal pole pattern applies no voltage: zero state
    function automatic logic is_zero_state(input logic [STATE_W-1:0] s);
        return (s == '0) || (s == '1);
    endfunction

    // Opposite active vectors drive the outermost hexagon vertices
    function automatic logic is_forbidden(input logic [STATE_W-1:0] s1,
                                          input logic [STATE_W-1:0] s2);
        return !is_zero_state(s1) && !is_zero_state(s2) && (s2 == ~s1);
    endfunction

    function automatic logic [COMBO_N-1:0] build_forbid_map();
        logic [COMBO_N-1:0] m;
        for (int i = 0; i < COMBO_N; i++) begin
            m[i] = is_forbidden(STATE_W'(i >> STATE_W), STATE_W'(i));
        end
        return m;
    endfunction

endpackage

// File: rtl/aux_combo_classifier.sv
module aux_combo_classifier
    import aux_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] inv1_state_i,
    input  logic [STATE_W-1:0] inv2_state_i,
    output logic               open_a_o,
    output logic               open_b_o,
    output logic               fault_o
);

    localparam int unsigned IDX_W = 2 * STATE_W;
    localparam logic [COMBO_N-1:0] FORBID_MAP = build_forbid_map();

    logic [IDX_W-1:0] idx;
    logic             forbid_now;

    assign idx        = {inv1_state_i, inv2_state_i};
    assign forbid_now = FORBID_MAP[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_a_o <= 1'b1;
            open_b_o <= 1'b1;
            fault_o  <= 1'b0;
        end else begin
            open_a_o <= is_zero_state(inv1_state_i) || forbid_now;
            open_b_o <= is_zero_state(inv2_state_i) || forbid_now;
            fault_o  <= forbid_now;
        end
    end

    // R5: flag tracks the previous cycle's pair, checked against the rule
    p_fault_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fault_o == is_forbidden($past(inv1_state_i), $past(inv2_state_i))));

    // R2: zero state on inverter 1 always requests pair A open
    p_zero_opens_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_zero_state(inv1_state_i) |=> open_a_o);

endmodule

// File: rtl/aux_alt_fsm.sv
module aux_alt_fsm
    import aux_seq_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned DEAD_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alt_mode_i,
    input  logic [PERIOD_W-1:0] half_period_i,
    input  logic [DEAD_W-1:0]   dead_len_i,
    input  logic                open_a_i,
    input  logic                open_b_i,
    input  logic                fault_i,
    output logic [3:0]          aux_close_o
);

    localparam int unsigned CNT_W = (PERIOD_W > DEAD_W) ? PERIOD_W : DEAD_W;

    seq_state_e       st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             per_done, dead_done;
    logic             close_a, close_b;

    assign per_done  = (cnt >= CNT_W'(half_period_i));
    assign dead_done = (cnt >= CNT_W'(dead_len_i));

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt + 1'b1;
        unique case (st)
            S_DECODE: begin
                cnt_nxt = '0;
                if (alt_mode_i) st_nxt = S_GAP_BA;
            end
            S_GAP_BA: if (dead_done) begin st_nxt = S_A_ON;   cnt_nxt = '0; end
            S_A_ON:   if (per_done)  begin st_nxt = S_GAP_AB; cnt_nxt = '0; end
            S_GAP_AB: if (dead_done) begin st_nxt = S_B_ON;   cnt_nxt = '0; end
            S_B_ON:   if (per_done)  begin st_nxt = S_GAP_BA; cnt_nxt = '0; end
            default:  begin st_nxt = S_DECODE; cnt_nxt = '0; end
        endcase
        if (st != S_DECODE && !alt_mode_i) begin
            st_nxt  = S_DECODE;
            cnt_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_DECODE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        close_a = 1'b0;
        close_b = 1'b0;
        unique case (st)
            S_DECODE: begin
                close_a = !open_a_i;
                close_b = !open_b_i;
            end
            S_A_ON:   close_a = 1'b1;
            S_B_ON:   close_b = 1'b1;
            S_GAP_BA, S_GAP_AB: ;
            default:  ;
        endcase
    end

    assign aux_close_o = {close_b, close_a, close_b, close_a};

    // R8: pairs never closed together while alternating
    p_pairs_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_DECODE) |-> !(aux_close_o[0] && aux_close_o[1]));

    // R8: break-before-make on each pair
    p_bbm_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != S_DECODE) && $rose(aux_close_o[0])) |-> !$past(aux_close_o[1]));
    p_bbm_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != S_DECODE) && $rose(aux_close_o[1])) |-> !$past(aux_close_o[0]));

    // R6: a flagged pair leaves all gates open in decode mode
    p_fault_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_DECODE) && fault_i) |-> (aux_close_o == 4'b0000));

    // R7: an expired on-interval leaves the on-state
    p_on_expires_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_A_ON) && per_done) |=> (st != S_A_ON));

    // R9: mode low always returns to decode
    p_mode_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_mode_i |=> (st == S_DECODE));

endmodule

// File: rtl/aux_switch_sequencer.sv
module aux_switch_sequencer
    import aux_seq_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned DEAD_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alt_mode_i,
    input  logic [2:0]          inv1_state_i,
    input  logic [2:0]          inv2_state_i,
    input  logic [PERIOD_W-1:0] half_period_i,
    input  logic [DEAD_W-1:0]   dead_len_i,
    output logic [3:0]          aux_close_o,
    output logic                fault_o
);

    logic open_a, open_b, fault_q;

    aux_combo_classifier u_class (
        .clk          (clk),
        .rst_n        (rst_n),
        .inv1_state_i (inv1_state_i),
        .inv2_state_i (inv2_state_i),
        .open_a_o     (open_a),
        .open_b_o     (open_b),
        .fault_o      (fault_q)
    );

    aux_alt_fsm #(
        .PERIOD_W (PERIOD_W),
        .DEAD_W   (DEAD_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .alt_mode_i    (alt_mode_i),
        .half_period_i (half_period_i),
        .dead_len_i    (dead_len_i),
        .open_a_i      (open_a),
        .open_b_i      (open_b),
        .fault_i       (fault_q),
        .aux_close_o   (aux_close_o)
    );

    assign fault_o = fault_q;

    // R1: both outputs quiet on the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (aux_close_o == 4'b0000 && !fault_o));

endmodule

// File: tb/test_aux_switch_sequencer.sv
module test_aux_switch_sequencer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alt_mode = 1'b0;
    logic [2:0]  s1 = 3'd0, s2 = 3'd0;
    logic [15:0] per = 16'd0;
    logic [7:0]  dead = 8'd0;
    logic [3:0]  aux;
    logic        fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state: 0 decode, 1 gap before A, 2 A on, 3 gap before B, 4 B on
    int m_phase = 0;
    int m_cnt = 0;
    bit m_open_a = 1, m_open_b = 1, m_fault = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_switch_sequencer i_aux_switch_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .alt_mode_i    (alt_mode),
        .inv1_state_i  (s1),
        .inv2_state_i  (s2),
        .half_period_i (per),
        .dead_len_i    (dead),
        .aux_close_o   (aux),
        .fault_o       (fault)
    );

    function automatic bit m_zero(input int s);
        return (s == 0) || (s == 7);
    endfunction

    function automatic bit m_forb(input int a, input int b);
        return !m_zero(a) && !m_zero(b) && (a + b == 7);
    endfunction

    task automatic model_edge();
        bit f;
        f = m_forb(int'(s1), int'(s2));
        if (!rst_n) begin
            m_open_a = 1; m_open_b = 1; m_fault = 0; m_phase = 0; m_cnt = 0;
            return;
        end
        m_open_a = m_zero(int'(s1)) || f;
        m_open_b = m_zero(int'(s2)) || f;
        m_fault  = f;
        if (m_phase == 0) begin
            m_cnt = 0;
            if (alt_mode) m_phase = 1;
        end else if (!alt_mode) begin
            m_phase = 0; m_cnt = 0;
        end else begin
            int lim;
            lim = (m_phase == 1 || m_phase == 3) ? int'(dead) : int'(per);
            if (m_cnt >= lim) begin
                m_phase = (m_phase == 4) ? 1 : m_phase + 1;
                m_cnt = 0;
            end else m_cnt++;
        end
    endtask

    function automatic logic [3:0] m_aux();
        bit a, b;
        case (m_phase)
            0: begin a = !m_open_a; b = !m_open_b; end
            2: begin a = 1; b = 0; end
            4: begin a = 0; b = 1; end
            default: begin a = 0; b = 0; end
        endcase
        return {b, a, b, a};
    endfunction

    function automatic string tag_aux();
        if (!rst_n) return "R1";
        if (m_phase != 0) return alt_mode ? "R7/R8/R10" : "R9";
        if (m_fault) return "R6";
        if (m_open_a && m_open_b) return "R2/R3";
        if (m_open_a) return "R2";
        if (m_open_b) return "R3";
        return "R4";
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: inputs already set; update model at edge, compare between edges
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag_aux(), aux, m_aux());
        check("R5 fault", {3'b0, fault}, {3'b0, m_fault});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        // R1: reset held, then released
        s1 = 3'b111; s2 = 3'b001;
        step(); step();
        check("R1 reset", aux, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post", {3'b0, fault}, 4'b0000);

        // R2 R3 R4 R5 R6: sweep all 64 combinations in decode mode
        for (int i = 0; i < 64; i++) begin
            s1 = 3'(i >> 3); s2 = 3'(i);
            step();
        end
        // pseudo-random decode patterns
        for (int i = 0; i < 100; i++) begin
            s1 = 3'($urandom_range(0, 7)); s2 = 3'($urandom_range(0, 7));
            step();
        end
        // R5: back-to-back forbidden pairs keep the flag high
        s1 = 3'b100; s2 = 3'b011; step();
        s1 = 3'b110; s2 = 3'b001; step();
        check("R5 held", {3'b0, fault}, 4'b0001);

        // R7 R8 R10: alternate with P=4 D=2, states wiggle
        per = 16'd4; dead = 8'd2;
        s1 = 3'b001; s2 = 3'b010; step();
        alt_mode = 1'b1;
        for (int i = 0; i < 60; i++) begin
            s1 = 3'($urandom_range(0, 7)); s2 = 3'($urandom_range(0, 7));
            step();
        end
        // R9: leave mid-cycle
        alt_mode = 1'b0; s1 = 3'b010; s2 = 3'b100; step();
        check("R9 decode closed", aux, 4'b1111);
        step();

        // R7: minimum intervals P=0 D=0
        per = 16'd0; dead = 8'd0; step();
        alt_mode = 1'b1;
        for (int i = 0; i < 20; i++) step();
        // R10: forbidden pair in alternate mode flags but gates keep pattern
        s1 = 3'b101; s2 = 3'b010;
        for (int i = 0; i < 6; i++) step();
        alt_mode = 1'b0; step(); step();
        check("R6 after exit", aux, 4'b0000);

        // R7: longer gap than on-phase
        per = 16'd1; dead = 8'd5; s1 = 3'b011; s2 = 3'b110; step();
        alt_mode = 1'b1;
        for (int i = 0; i < 40; i++) step();
        alt_mode = 1'b0; step();

        // reset in the middle of alternation, R1
        alt_mode = 1'b1; for (int i = 0; i < 5; i++) step();
        rst_n = 1'b0; step();
        check("R1 mid reset", aux, 4'b0000);
        rst_n = 1'b1; alt_mode = 1'b0; step(); step();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule